// File: doc/BRIEF.md
# Conversion-Complete Interrupt Source Cell

This cell sits beside a data converter and turns its "result written" pulse into an interrupt request for the CPU. It keeps four pieces of state: a pending-event flag, an enable bit, a priority level and a small control register. Software reaches all of them through a narrow write port and a combinational read port. The control register picks how software writes to the flag, and whether the event goes to the CPU or to a DMA engine.

The registered request line rises only when every gate is open. The gates are: the flag is set, the cell is enabled, no more urgent source is waiting, the CPU accepts interrupts globally, and the programmed level is strictly above the CPU's current level. When DMA routing is selected, each event instead sends a one-cycle DMA trigger and parks the cell in a waiting state. While it waits, the CPU request is held off. When the DMA engine reports completion, the normal gating applies again.

Top module: `evt_irq_gate`

## Requirements
- R1: A high `evt_done` at a clock edge sets the flag. Reading select 0 returns the flag in bit 0, with all other bits zero.
- R2: In clear-on-one mode (control bit 0 = 0), writing select 0 with data bit 0 = 1 clears the flag. Writing it with data bit 0 = 0 leaves the flag unchanged.
- R3: In direct mode (control bit 0 = 1), a write to select 0 loads data bit 0 into the flag, so 1 sets it and 0 clears it.
- R4: When `evt_done` and a clearing write to select 0 occur at the same edge, the flag ends up set.
- R5: After reset, the enable bit (select 1, bit 0) reads 0 and the control register (select 3: bit 0 write mode, bit 1 DMA routing) reads 0. The enable bit follows each write to select 1 and reads back.
- R6: `irq_req` is high in the cycle after an edge at which all of these hold: flag=1, enable=1, `hp_pending`=0, `cpu_ie`=1, priority > `cpu_level`, and no DMA wait is active.
- R7: `irq_req` falls in the cycle after the flag is cleared or any gate in R6 closes.
- R8: With DMA routing (control bit 1 = 1), each `evt_done` makes `dma_req` high for exactly the following cycle. From then on `irq_req` stays low until `dma_done` arrives.
- R9: After `dma_done` is seen at an edge, the wait ends. If the flag is still set and the gates of R6 are open, `irq_req` rises one cycle later.
- R10: A write to select 2 stores data bits [LVL_W-1:0] as the priority level. Reading select 2 returns it, with the upper bits zero. The level has no reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 flag, 1 enable, 2 level, 3 control |
| wr_data | input | DW | Write data |
| rd_sel | input | 2 | Read select, same encoding |
| rd_data | output | DW | Read data (combinational) |
| evt_done | input | 1 | Conversion-complete pulse |
| dma_done | input | 1 | DMA transfer-complete pulse |
| hp_pending | input | 1 | A higher-priority request is pending |
| cpu_ie | input | 1 | CPU global interrupt enable |
| cpu_level | input | LVL_W | CPU current interrupt level |
| irq_req | output | 1 | Registered CPU interrupt request |
| dma_req | output | 1 | One-cycle DMA trigger |

## Verification
The bench builds the cell with its default parameters, LVL_W=3 and DW=8. With only eight levels, the bench can sweep every pairing of programmed level and CPU level, which exercises the strict greater-than comparison at both ends and at equality. An 8-bit data path is wide enough to show that reads of the narrow fields return zero in their upper bits. A behavioural model of all registers and outputs is checked against the design on every clock. It is driven through both flag write modes, same-edge set/clear collisions, and a full DMA hand-off sequence.

// File: rtl/evt_irq_gate.sv
module evt_irq_gate #(
  parameter int LVL_W = 3,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [1:0]       rd_sel,
  output logic [DW-1:0]    rd_data,
  input  logic             evt_done,
  input  logic             dma_done,
  input  logic             hp_pending,
  input  logic             cpu_ie,
  input  logic [LVL_W-1:0] cpu_level,
  output logic             irq_req,
  output logic             dma_req
);
  localparam logic [1:0] SEL_FLAG = 2'd0;
  localparam logic [1:0] SEL_EN   = 2'd1;
  localparam logic [1:0] SEL_LVL  = 2'd2;
  localparam logic [1:0] SEL_CTL  = 2'd3;

  logic             flag, en, wmode, dma_sel, dma_pend;
  logic [LVL_W-1:0] prio;

  wire wr_flag = wr_en && (wr_sel == SEL_FLAG);
  wire wr_en_b = wr_en && (wr_sel == SEL_EN);
  wire wr_lvl  = wr_en && (wr_sel == SEL_LVL);
  wire wr_ctl  = wr_en && (wr_sel == SEL_CTL);

  wire gate_open = flag && en && !hp_pending && cpu_ie &&
                   (prio > cpu_level) && !dma_pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        flag <= 1'b0;
    else if (evt_done) flag <= 1'b1;
    else if (wr_flag)  flag <= wmode ? wr_data[0] : (flag & ~wr_data[0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       en <= 1'b0;
    else if (wr_en_b) en <= wr_data[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wmode   <= 1'b0;
      dma_sel <= 1'b0;
    end else if (wr_ctl) begin
      wmode   <= wr_data[0];
      dma_sel <= wr_data[1];
    end

  always_ff @(posedge clk)
    if (wr_lvl) prio <= wr_data[LVL_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dma_pend <= 1'b0;
      dma_req  <= 1'b0;
      irq_req  <= 1'b0;
    end else begin
      dma_req <= evt_done && dma_sel;
      irq_req <= gate_open;
      if (evt_done && dma_sel) dma_pend <= 1'b1;
      else if (dma_done)       dma_pend <= 1'b0;
    end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_FLAG: rd_data[0]         = flag;
      SEL_EN:   rd_data[0]         = en;
      SEL_LVL:  rd_data[LVL_W-1:0] = prio;
      default:  rd_data[1:0]       = {dma_sel, wmode};
    endcase
  end
endmodule

module evt_irq_gate_chk #(
  parameter int LVL_W = 3,
  parameter int DW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [DW-1:0] wr_data,
  input logic          evt_done,
  input logic          cpu_ie,
  input logic          hp_pending,
  input logic          irq_req,
  input logic          dma_req,
  input logic          flag,
  input logic          wmode,
  input logic          dma_pend
);
  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) evt_done |=> flag); // R1
  AST_W1C_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && !wmode && !wr_data[0] && !evt_done) |=> $stable(flag)); // R2
  AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done && wr_en && wr_sel == 2'd0) |=> flag); // R4
  AST_IRQ_NEEDS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(flag && cpu_ie && !hp_pending)); // R6
  AST_IRQ_DROPS_IE: assert property (@(posedge clk) disable iff (!rst_n) !cpu_ie |=> !irq_req); // R7
  AST_DMA_FROM_EVT: assert property (@(posedge clk) disable iff (!rst_n) $rose(dma_req) |-> $past(evt_done)); // R8
  AST_DMA_HOLDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) dma_pend |=> !irq_req); // R8
endmodule

bind evt_irq_gate evt_irq_gate_chk #(.LVL_W(LVL_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .evt_done(evt_done), .cpu_ie(cpu_ie), .hp_pending(hp_pending),
  .irq_req(irq_req), .dma_req(dma_req), .flag(flag), .wmode(wmode), .dma_pend(dma_pend)
);

// File: tb/evt_irq_gate_bench.sv
module evt_irq_gate_bench;
  localparam int LVL_W = 3;
  localparam int DW    = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, evt_done = 0, dma_done = 0, hp_pending = 0, cpu_ie = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [DW-1:0] wr_data = 0;
  logic [LVL_W-1:0] cpu_level = 0;
  logic [DW-1:0] rd_data;
  logic irq_req, dma_req;

  int checks = 0, errors = 0;
  bit run = 0, finished = 0;

  always #10 clk = ~clk;

  evt_irq_gate #(.LVL_W(LVL_W), .DW(DW)) u_evt_irq_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .evt_done(evt_done), .dma_done(dma_done),
    .hp_pending(hp_pending), .cpu_ie(cpu_ie), .cpu_level(cpu_level),
    .irq_req(irq_req), .dma_req(dma_req));

  // behavioural reference model
  int m_flag, m_en, m_prio, m_pk, m_wm, m_ds, m_pend, m_irq, m_dma;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = 0; m_en = 0; m_pk = 0; m_prio = 0; m_wm = 0; m_ds = 0;
      m_pend = 0; m_irq = 0; m_dma = 0;
    end else begin
      int nf, ne, np, nk, nw, nd, npd, ni, nm;
      nf = m_flag; ne = m_en; np = m_prio; nk = m_pk; nw = m_wm; nd = m_ds; npd = m_pend;
      ni = (m_flag && m_en && !hp_pending && cpu_ie && m_pk && m_prio > int'(cpu_level) && !m_pend) ? 1 : 0;
      nm = (evt_done && m_ds) ? 1 : 0;
      if (wr_en) begin
        case (wr_sel)
          0: nf = m_wm ? int'(wr_data[0]) : (wr_data[0] ? 0 : m_flag);
          1: ne = wr_data[0];
          2: begin np = wr_data[LVL_W-1:0]; nk = 1; end
          default: begin nw = wr_data[0]; nd = wr_data[1]; end
        endcase
      end
      if (evt_done) nf = 1;
      if (evt_done && m_ds) npd = 1; else if (dma_done) npd = 0;
      m_flag = nf; m_en = ne; m_prio = np; m_pk = nk; m_wm = nw; m_ds = nd;
      m_pend = npd; m_irq = ni; m_dma = nm;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && run && !finished) begin
    chk("R6 irq_req vs model", irq_req, m_irq);
    chk("R8 dma_req vs model", dma_req, m_dma);
    case (rd_sel)
      0: chk("R1 flag read vs model", rd_data, m_flag);
      1: chk("R5 enable read vs model", rd_data, m_en);
      2: if (m_pk) chk("R10 level read vs model", rd_data, m_prio);
      default: chk("R5 control read vs model", rd_data, m_ds * 2 + m_wm);
    endcase
  end

  task automatic tick(); @(negedge clk); #1; endtask
  task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; tick(); wr_en = 0;
  endtask
  task automatic rd(input logic [1:0] s, output int v);
    rd_sel = s; #1; v = rd_data;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) tick();
    rst_n = 1; run = 1; tick();
    rd(1, v); chk("R5 enable after reset", v, 0);
    rd(3, v); chk("R5 control after reset", v, 0);
    rd(0, v); chk("R1 flag after reset", v, 0);
    chk("R6 irq after reset", irq_req, 0);

    wr(2, 8'hFD); rd(2, v); chk("R10 level keeps low bits", v, 5);
    wr(1, 8'h01); rd(1, v); chk("R5 enable written", v, 1);
    cpu_ie = 1; cpu_level = 2;
    evt_done = 1; tick(); evt_done = 0;
    rd(0, v); chk("R1 flag set by event", v, 1);
    chk("R6 irq not yet", irq_req, 0);
    tick(); chk("R6 irq raised", irq_req, 1);
    cpu_level = 5; tick(); chk("R7 level equal drops irq", irq_req, 0);
    cpu_level = 4; tick(); chk("R6 level below raises irq", irq_req, 1);
    hp_pending = 1; tick(); chk("R7 higher pending drops irq", irq_req, 0);
    hp_pending = 0; tick(); chk("R6 irq back", irq_req, 1);
    cpu_ie = 0; tick(); chk("R7 global disable drops irq", irq_req, 0);
    cpu_ie = 1; tick();

    wr(0, 8'h00); rd(0, v); chk("R2 write 0 no effect", v, 1);
    wr(0, 8'h01); rd(0, v); chk("R2 write 1 clears", v, 0);
    tick(); chk("R7 irq drops after clear", irq_req, 0);

    evt_done = 1; wr(0, 8'h01); evt_done = 0;
    rd(0, v); chk("R4 event wins over clear", v, 1);

    wr(3, 8'h01); rd(3, v); chk("R5 control written", v, 1);
    wr(0, 8'h00); rd(0, v); chk("R3 write 0 clears", v, 0);
    wr(0, 8'h01); rd(0, v); chk("R3 write 1 sets", v, 1);

    for (int p = 0; p < 8; p++) begin
      wr(2, DW'(p));
      for (int l = 0; l < 8; l++) begin
        cpu_level = LVL_W'(l); tick(); tick();
        chk("R6 level compare sweep", irq_req, p > l ? 1 : 0);
      end
    end

    wr(0, 8'h00); wr(2, 8'h07); cpu_level = 0;
    wr(3, 8'h02); rd(3, v); chk("R5 control dma route", v, 2);
    evt_done = 1; tick(); evt_done = 0;
    chk("R8 dma pulse", dma_req, 1);
    tick(); chk("R8 dma pulse single", dma_req, 0);
    repeat (4) tick();
    chk("R8 irq held during dma", irq_req, 0);
    dma_done = 1; tick(); dma_done = 0;
    chk("R9 irq not on done edge", irq_req, 0);
    tick(); chk("R9 irq after dma done", irq_req, 1);
    evt_done = 1; tick(); evt_done = 0;
    chk("R8 second dma pulse", dma_req, 1);
    tick(); chk("R8 irq withheld again", irq_req, 0);
    rd(0, v); chk("R1 flag still set", v, 1);
    repeat (2) tick();
    finish_run();
  end
endmodule